// File: doc/BRIEF.md
# Width-Selectable Increment/Decrement Unit

This unit executes the increment and decrement operations of a 16-bit accumulator processor whose register widths can be switched at run time. A sequencer hands it a decoded opcode together with the accumulator, the two index registers, the direct-page register, the two width flags and an effective address that has already been computed. Register forms update the chosen register in a single step. Memory forms run a read-modify-write over a simple synchronous byte port.

On completion the unit reports the updated register values, the negative and zero flags, and the number of processor cycles that the instruction is charged. In 8-bit operation only the low byte of a register changes, and the high byte is kept. The cycle charge depends on the addressing form, on the operand width and on whether the low byte of the direct-page register is zero. An opcode outside the supported set is reported as illegal and changes nothing.

Top module: `incdec_unit`

## Requirements
- R1: Fourteen opcodes are supported. Accumulator: 0x1A increment, 0x3A decrement. Index: 0xE8 increment X, 0xCA decrement X, 0xC8 increment Y, 0x88 decrement Y. Memory increment: 0xEE absolute, 0xFE absolute-X, 0xE6 direct, 0xF6 direct-X. Memory decrement: 0xCE, 0xDE, 0xC6, 0xD6 in the same four forms. Any other opcode accepted by `start` gives a one-cycle `illegal` pulse in the cycle after the start edge. It produces no `done`, no memory access, and no change to the register, flag or cycle outputs.
- R2: A 16-bit register operation wraps modulo 65536. The new value appears on the target register output in the cycle after the start edge, together with a one-cycle `done`. The other two register outputs take the values presented at start.
- R3: A width flag held high selects 8-bit operation. `m_flag` governs the accumulator and memory forms, and `x_flag` governs the X and Y forms. In 8-bit operation the low byte wraps modulo 256 and the high byte is unchanged.
- R4: `flag_n` and `flag_z` follow the result at the active width. In 8-bit operation they use bit 7 and the low byte. In 16-bit operation they use bit 15 and the whole word.
- R5: An 8-bit memory form reads the byte at the effective address, then writes the modified byte back to that address. `done` is high 3 cycles after the start edge. `mem_rd` and `mem_wr` are never high together.
- R6: A 16-bit memory form treats the word as little-endian: the low byte is at the effective address and the high byte at address+1. It reads the low byte, then the high byte, then modifies the word. It then writes the high byte first and the low byte last, and `done` is high 5 cycles after the start edge, in the cycle the last write ends.
- R7: Every register form, including those on the accumulator, is charged 2 cycles in either width.
- R8: The memory forms are charged 6, 7, 5 and 6 cycles for absolute, absolute-X, direct and direct-X with an 8-bit operand. A 16-bit operand adds 2 cycles to each.
- R9: The direct and direct-X forms are charged 1 extra cycle when the low byte of `dp_in` is nonzero.
- R10: A `start` that arrives while a memory sequence is in progress is ignored.
- R11: While `rst_n` is low, all register, flag and cycle outputs are zero, and `done`, `illegal`, `mem_rd` and `mem_wr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| opcode | input | 8 | Opcode of the operation |
| m_flag | input | 1 | High: 8-bit accumulator and memory operand |
| x_flag | input | 1 | High: 8-bit index operand |
| acc_in | input | 16 | Accumulator value |
| xr_in | input | 16 | X register value |
| yr_in | input | 16 | Y register value |
| dp_in | input | 16 | Direct-page register value |
| ea_in | input | 24 | Effective address for memory forms |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| mem_addr | output | 24 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| acc_out | output | 16 | Accumulator after the operation |
| xr_out | output | 16 | X register after the operation |
| yr_out | output | 16 | Y register after the operation |
| flag_n | output | 1 | Negative flag of the last result |
| flag_z | output | 1 | Zero flag of the last result |
| cyc_count | output | 4 | Cycles charged for the last instruction |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle unsupported-opcode pulse |

## Verification
Each result has a fixed due time, counted from the clock edge that samples `start`. Register results, flags and `illegal` are registered at that edge. An 8-bit memory form completes three edges later, and a 16-bit form five edges later. Every scenario task drives its inputs on a falling edge and then counts exactly that many falling edges before it samples. It then checks one falling edge later that `done` has dropped again, which pins the pulse to a single cycle. Bus activity is counted by the bench's own memory model, which also records the order of the write addresses. These records are compared with the number of reads and writes, and the write order, that each form calls for.

// File: rtl/incdec_pkg.sv
package incdec_pkg;

   typedef enum logic [1:0] {TGT_A, TGT_X, TGT_Y, TGT_MEM} tgt_e;
   typedef enum logic [1:0] {AM_ABS, AM_ABSX, AM_DP, AM_DPX} amode_e;

   typedef struct packed {
      logic   legal;
      logic   dec;
      tgt_e   tgt;
      amode_e mode;
   } op_t;

   typedef enum logic [2:0] {
      ST_IDLE, ST_RD_LO, ST_RD_HI, ST_MOD, ST_WR_HI, ST_WR_LO
   } st_e;

endpackage

// File: rtl/incdec_decode.sv
module incdec_decode
   import incdec_pkg::*;
(
   input  logic [7:0] opcode,
   output op_t        op
);
   always_comb begin
      op = '{legal: 1'b1, dec: 1'b0, tgt: TGT_MEM, mode: AM_ABS};
      case (opcode)
         8'h1A: op.tgt = TGT_A;
         8'h3A: begin op.tgt = TGT_A; op.dec = 1'b1; end
         8'hE8: op.tgt = TGT_X;
         8'hCA: begin op.tgt = TGT_X; op.dec = 1'b1; end
         8'hC8: op.tgt = TGT_Y;
         8'h88: begin op.tgt = TGT_Y; op.dec = 1'b1; end
         8'hEE: op.mode = AM_ABS;
         8'hFE: op.mode = AM_ABSX;
         8'hE6: op.mode = AM_DP;
         8'hF6: op.mode = AM_DPX;
         8'hCE: begin op.mode = AM_ABS;  op.dec = 1'b1; end
         8'hDE: begin op.mode = AM_ABSX; op.dec = 1'b1; end
         8'hC6: begin op.mode = AM_DP;   op.dec = 1'b1; end
         8'hD6: begin op.mode = AM_DPX;  op.dec = 1'b1; end
         default: op.legal = 1'b0;
      endcase
   end
endmodule

// File: rtl/incdec_alu.sv
module incdec_alu #(
   parameter int DATA_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic [DATA_W-1:0] opnd,
   input  logic              dec,
   input  logic              wide,
   output logic [DATA_W-1:0] res,
   output logic              neg,
   output logic              zero
);
   localparam int HI_W = DATA_W - BYTE_W;

   if (DATA_W != 2 * BYTE_W) begin : g_bad_split
      $error("incdec_alu: DATA_W must be twice BYTE_W");
   end

   logic [DATA_W-1:0] full_step;
   logic [BYTE_W-1:0] low_step;

   always_comb begin
      full_step = dec ? opnd - DATA_W'(1) : opnd + DATA_W'(1);
      low_step  = dec ? opnd[BYTE_W-1:0] - BYTE_W'(1)
                      : opnd[BYTE_W-1:0] + BYTE_W'(1);
      if (wide) begin
         res  = full_step;
         neg  = full_step[DATA_W-1];
         zero = (full_step == '0);
      end else begin
         res  = {opnd[DATA_W-1:DATA_W-HI_W], low_step};
         neg  = low_step[BYTE_W-1];
         zero = (low_step == '0);
      end
   end
endmodule

// File: rtl/incdec_cost.sv
module incdec_cost
   import incdec_pkg::*;
#(
   parameter int CYC_W      = 4,
   parameter int REG_COST   = 2,
   parameter int ABS_COST   = 6,
   parameter int ABSX_COST  = 7,
   parameter int DP_COST    = 5,
   parameter int DPX_COST   = 6,
   parameter int WIDE_EXTRA = 2,
   parameter int DP_EXTRA   = 1
) (
   input  op_t              op,
   input  logic             wide,
   input  logic             dp_lo_nz,
   output logic [CYC_W-1:0] cycles
);
   localparam int MAX_COST = ABSX_COST + WIDE_EXTRA + DP_EXTRA;

   if (MAX_COST >= (1 << CYC_W)) begin : g_bad_cyc_w
      $error("incdec_cost: CYC_W too narrow for the largest cost");
   end

   always_comb begin
      if (op.tgt != TGT_MEM) begin
         cycles = CYC_W'(REG_COST);
      end else begin
         case (op.mode)
            AM_ABS:  cycles = CYC_W'(ABS_COST);
            AM_ABSX: cycles = CYC_W'(ABSX_COST);
            AM_DP:   cycles = CYC_W'(DP_COST);
            default: cycles = CYC_W'(DPX_COST);
         endcase
         if (wide) cycles = cycles + CYC_W'(WIDE_EXTRA);
         if (dp_lo_nz && (op.mode == AM_DP || op.mode == AM_DPX))
            cycles = cycles + CYC_W'(DP_EXTRA);
      end
   end
endmodule

// File: rtl/incdec_unit.sv
module incdec_unit
   import incdec_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 16,
   parameter int BYTE_W = 8,
   parameter int CYC_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [7:0]        opcode,
   input  logic              m_flag,
   input  logic              x_flag,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [DATA_W-1:0] xr_in,
   input  logic [DATA_W-1:0] yr_in,
   input  logic [DATA_W-1:0] dp_in,
   input  logic [ADDR_W-1:0] ea_in,
   input  logic [BYTE_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [BYTE_W-1:0] mem_wdata,
   output logic [DATA_W-1:0] acc_out,
   output logic [DATA_W-1:0] xr_out,
   output logic [DATA_W-1:0] yr_out,
   output logic              flag_n,
   output logic              flag_z,
   output logic [CYC_W-1:0]  cyc_count,
   output logic              done,
   output logic              illegal
);
   localparam int HI_W     = DATA_W - BYTE_W;
   localparam int MIN_COST = 2;
   localparam int MAX_COST = 10;

   if (DATA_W != 2 * BYTE_W) begin : g_bad_split
      $error("incdec_unit: DATA_W must be twice BYTE_W");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("incdec_unit: ADDR_W too small");
   end

   op_t               dop;
   st_e               state;
   logic              accept, wide_in, is_reg;
   logic [DATA_W-1:0] reg_opnd, mem_opnd, alu_opnd, alu_res, res_q;
   logic              alu_dec, alu_wide, alu_n, alu_z;
   logic [CYC_W-1:0]  cost, cyc_pend;
   logic [ADDR_W-1:0] ea_q;
   logic [BYTE_W-1:0] lo_q;
   logic              dec_q, wide_q, n_pend, z_pend;

   incdec_decode u_dec (.opcode(opcode), .op(dop));

   assign accept  = start && (state == ST_IDLE);
   assign is_reg  = (dop.tgt != TGT_MEM);
   assign wide_in = (dop.tgt == TGT_X || dop.tgt == TGT_Y) ? !x_flag : !m_flag;

   always_comb begin
      case (dop.tgt)
         TGT_X:   reg_opnd = xr_in;
         TGT_Y:   reg_opnd = yr_in;
         default: reg_opnd = acc_in;
      endcase
   end

   assign mem_opnd = wide_q ? {mem_rdata, lo_q} : {{HI_W{1'b0}}, mem_rdata};
   assign alu_opnd = (state == ST_MOD) ? mem_opnd : reg_opnd;
   assign alu_dec  = (state == ST_MOD) ? dec_q    : dop.dec;
   assign alu_wide = (state == ST_MOD) ? wide_q   : wide_in;

   incdec_alu #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_alu (
      .opnd(alu_opnd), .dec(alu_dec), .wide(alu_wide),
      .res(alu_res), .neg(alu_n), .zero(alu_z)
   );

   incdec_cost #(.CYC_W(CYC_W)) u_cost (
      .op(dop), .wide(wide_in), .dp_lo_nz(dp_in[BYTE_W-1:0] != '0),
      .cycles(cost)
   );

   // Bus drive follows the sequencer state.
   always_comb begin
      mem_rd    = (state == ST_RD_LO) || (state == ST_RD_HI);
      mem_wr    = (state == ST_WR_HI) || (state == ST_WR_LO);
      mem_addr  = (state == ST_RD_HI || state == ST_WR_HI) ? ea_q + ADDR_W'(1) : ea_q;
      mem_wdata = (state == ST_WR_HI) ? res_q[DATA_W-1:BYTE_W] : res_q[BYTE_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         acc_out   <= '0;
         xr_out    <= '0;
         yr_out    <= '0;
         flag_n    <= 1'b0;
         flag_z    <= 1'b0;
         cyc_count <= '0;
         done      <= 1'b0;
         illegal   <= 1'b0;
         cyc_pend  <= '0;
         ea_q      <= '0;
         lo_q      <= '0;
         res_q     <= '0;
         dec_q     <= 1'b0;
         wide_q    <= 1'b0;
         n_pend    <= 1'b0;
         z_pend    <= 1'b0;
      end else begin
         done    <= 1'b0;
         illegal <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (accept && !dop.legal) begin
                  illegal <= 1'b1;
               end else if (accept) begin
                  acc_out <= acc_in;
                  xr_out  <= xr_in;
                  yr_out  <= yr_in;
                  if (is_reg) begin
                     case (dop.tgt)
                        TGT_X:   xr_out  <= alu_res;
                        TGT_Y:   yr_out  <= alu_res;
                        default: acc_out <= alu_res;
                     endcase
                     flag_n    <= alu_n;
                     flag_z    <= alu_z;
                     cyc_count <= cost;
                     done      <= 1'b1;
                  end else begin
                     ea_q     <= ea_in;
                     dec_q    <= dop.dec;
                     wide_q   <= wide_in;
                     cyc_pend <= cost;
                     state    <= ST_RD_LO;
                  end
               end
            end
            ST_RD_LO: state <= wide_q ? ST_RD_HI : ST_MOD;
            ST_RD_HI: begin
               lo_q  <= mem_rdata;
               state <= ST_MOD;
            end
            ST_MOD: begin
               res_q  <= alu_res;
               n_pend <= alu_n;
               z_pend <= alu_z;
               state  <= wide_q ? ST_WR_HI : ST_WR_LO;
            end
            ST_WR_HI: state <= ST_WR_LO;
            ST_WR_LO: begin
               flag_n    <= n_pend;
               flag_z    <= z_pend;
               cyc_count <= cyc_pend;
               done      <= 1'b1;
               state     <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // Checks next to the sequencer.
   logic acc8_hit;
   assign acc8_hit = accept && dop.legal && (dop.tgt == TGT_A) && m_flag;

   assert_bus_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));
   assert_done_last_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_wr) |-> done);
   assert_illegal_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> ($stable(acc_out) && $stable(xr_out) && $stable(yr_out)
                   && $stable(cyc_count) && !done));
   assert_high_byte_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      acc8_hit |=> acc_out[DATA_W-1:BYTE_W] == $past(acc_in[DATA_W-1:BYTE_W]));
   assert_flags_coherent_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && flag_z) |-> !flag_n);
   assert_cost_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cyc_count >= CYC_W'(MIN_COST) && cyc_count <= CYC_W'(MAX_COST)));
endmodule

// File: tb/incdec_unit_test.sv
module incdec_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  opcode = 8'h00;
   logic        m_flag = 1'b0, x_flag = 1'b0;
   logic [15:0] acc_in = '0, xr_in = '0, yr_in = '0, dp_in = '0;
   logic [23:0] ea_in = '0;
   logic [7:0]  mem_rdata;
   logic [23:0] mem_addr;
   logic        mem_rd, mem_wr;
   logic [7:0]  mem_wdata;
   logic [15:0] acc_out, xr_out, yr_out;
   logic        flag_n, flag_z, done, illegal;
   logic [3:0]  cyc_count;

   int tests = 0, fails = 0;
   int rd_cnt = 0, wr_cnt = 0;
   logic [23:0] prev_wa = '0, last_wa = '0;
   logic [7:0]  mem [256];

   always #5 clk = ~clk;

   incdec_unit uut (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
      .m_flag(m_flag), .x_flag(x_flag), .acc_in(acc_in), .xr_in(xr_in),
      .yr_in(yr_in), .dp_in(dp_in), .ea_in(ea_in), .mem_rdata(mem_rdata),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .acc_out(acc_out), .xr_out(xr_out),
      .yr_out(yr_out), .flag_n(flag_n), .flag_z(flag_z),
      .cyc_count(cyc_count), .done(done), .illegal(illegal)
   );

   // Synchronous byte memory model with access log.
   always @(posedge clk) begin
      if (mem_rd) begin
         mem_rdata <= mem[mem_addr[7:0]];
         rd_cnt    <= rd_cnt + 1;
      end
      if (mem_wr) begin
         mem[mem_addr[7:0]] <= mem_wdata;
         wr_cnt  <= wr_cnt + 1;
         prev_wa <= last_wa;
         last_wa <= mem_addr;
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_cost(input logic [7:0] opc,
                                           input logic wide, input logic [15:0] dp);
      int c;
      case (opc)
         8'hEE, 8'hCE: c = 6;
         8'hFE, 8'hDE: c = 7;
         8'hE6, 8'hC6: c = 5;
         8'hF6, 8'hD6: c = 6;
         default:      c = 2;
      endcase
      if (c != 2 || opc == 8'hF6 || opc == 8'hD6) begin
         if (wide) c += 2;
         if ((opc == 8'hE6 || opc == 8'hC6 || opc == 8'hF6 || opc == 8'hD6)
             && dp[7:0] != 8'h00) c += 1;
      end
      return 4'(c);
   endfunction

   // Starts an operation, then waits lat falling edges past the one after the start edge.
   task automatic issue(input logic [7:0] opc, input logic m, input logic x,
                        input logic [15:0] a, input logic [15:0] xv, input logic [15:0] yv,
                        input logic [15:0] dp, input logic [23:0] ea, input int lat);
      @(negedge clk);
      opcode = opc; m_flag = m; x_flag = x; acc_in = a; xr_in = xv; yr_in = yv;
      dp_in = dp; ea_in = ea; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (lat) @(negedge clk);
   endtask

   task automatic pulse_ends(input string req);
      @(negedge clk);
      chk(req, "done pulse one cycle", done, 1'b0);
   endtask

   task automatic t_reset;
      chk("R11", "acc_out", acc_out, 16'h0);
      chk("R11", "cyc_count", cyc_count, 4'h0);
      chk("R11", "done/illegal/rd/wr", {done, illegal, mem_rd, mem_wr}, 4'b0000);
   endtask

   task automatic t_reg16;
      issue(8'h1A, 1'b0, 1'b0, 16'h12FF, 16'h1111, 16'h2222, 16'h0, 24'h0, 0);
      chk("R2", "inc A 16 result", acc_out, 16'h1300);
      chk("R2", "done", done, 1'b1);
      chk("R2", "X passthrough", xr_out, 16'h1111);
      chk("R7", "register cost", cyc_count, exp_cost(8'h1A, 1'b1, 16'h0));
      pulse_ends("R2");
      issue(8'h3A, 1'b0, 1'b1, 16'h0000, 16'h0, 16'h0, 16'h0, 24'h0, 0);
      chk("R2", "dec A wraps", acc_out, 16'hFFFF);
      chk("R4", "N/Z after FFFF", {flag_n, flag_z}, 2'b10);
   endtask

   task automatic t_reg8;
      issue(8'h1A, 1'b1, 1'b0, 16'h34FF, 16'h0, 16'h0, 16'h0, 24'h0, 0);
      chk("R3", "inc A 8-bit keeps high byte", acc_out, 16'h3400);
      chk("R4", "Z from low byte", {flag_n, flag_z}, 2'b01);
      issue(8'hCA, 1'b0, 1'b1, 16'h5555, 16'hAB00, 16'h0, 16'h0, 24'h0, 0);
      chk("R3", "dec X 8-bit", xr_out, 16'hABFF);
      chk("R4", "N from bit 7", {flag_n, flag_z}, 2'b10);
      chk("R2", "A passthrough", acc_out, 16'h5555);
      chk("R7", "8-bit register cost", cyc_count, 4'd2);
      issue(8'hC8, 1'b1, 1'b0, 16'h0, 16'h0, 16'h7FFF, 16'h0, 24'h0, 0);
      chk("R3", "inc Y 16 ignores m_flag", yr_out, 16'h8000);
      chk("R4", "N from bit 15", {flag_n, flag_z}, 2'b10);
      issue(8'h88, 1'b0, 1'b1, 16'h0, 16'h0, 16'h0101, 16'h0, 24'h0, 0);
      chk("R3", "dec Y 8-bit to zero", yr_out, 16'h0100);
      chk("R4", "Z ignores high byte", {flag_n, flag_z}, 2'b01);
      issue(8'hE8, 1'b1, 1'b0, 16'h0, 16'hFFFF, 16'h0, 16'h0, 24'h0, 0);
      chk("R2", "inc X 16 wraps", xr_out, 16'h0000);
   endtask

   task automatic t_mem8;
      int r0, w0;
      mem[8'h40] = 8'hFF;
      r0 = rd_cnt; w0 = wr_cnt;
      issue(8'hEE, 1'b1, 1'b0, 16'hBEEF, 16'h0, 16'h0, 16'h0, 24'h000040, 2);
      chk("R5", "done not early", done, 1'b0);
      @(negedge clk);
      chk("R5", "done at 3 cycles", done, 1'b1);
      chk("R5", "mem byte", mem[8'h40], 8'h00);
      chk("R5", "one read one write", {16'(rd_cnt - r0), 16'(wr_cnt - w0)}, 32'h0001_0001);
      chk("R4", "Z from memory byte", {flag_n, flag_z}, 2'b01);
      chk("R8", "abs 8 cost", cyc_count, exp_cost(8'hEE, 1'b0, 16'h0));
      chk("R5", "A passthrough", acc_out, 16'hBEEF);
      pulse_ends("R5");
      mem[8'h30] = 8'h81;
      issue(8'hC6, 1'b1, 1'b0, 16'h0, 16'h0, 16'h0, 16'h0005, 24'h000030, 3);
      chk("R5", "dec dp byte", mem[8'h30], 8'h80);
      chk("R9", "dp 8 cost with nonzero low", cyc_count, exp_cost(8'hC6, 1'b0, 16'h0005));
      mem[8'h31] = 8'h10;
      issue(8'hF6, 1'b1, 1'b0, 16'h0, 16'h0, 16'h0, 16'h0300, 24'h000031, 3);
      chk("R9", "dpX 8 cost with zero low", cyc_count, 4'd6);
   endtask

   task automatic t_mem16;
      int r0, w0;
      mem[8'h50] = 8'h00; mem[8'h51] = 8'h00;
      r0 = rd_cnt; w0 = wr_cnt;
      issue(8'hD6, 1'b0, 1'b1, 16'h0, 16'h0, 16'h0, 16'h0100, 24'h000050, 4);
      chk("R6", "done not early", done, 1'b0);
      @(negedge clk);
      chk("R6", "done at 5 cycles", done, 1'b1);
      chk("R6", "word result", {mem[8'h51], mem[8'h50]}, 16'hFFFF);
      chk("R6", "two reads two writes", {16'(rd_cnt - r0), 16'(wr_cnt - w0)}, 32'h0002_0002);
      chk("R6", "high byte written first", {prev_wa, last_wa}, {24'h000051, 24'h000050});
      chk("R9", "dpX 16 cost, zero low", cyc_count, exp_cost(8'hD6, 1'b1, 16'h0100));
      chk("R4", "N on 16-bit memory", {flag_n, flag_z}, 2'b10);
      mem[8'h60] = 8'hFF; mem[8'h61] = 8'h7F;
      issue(8'hFE, 1'b0, 1'b0, 16'h0, 16'h0, 16'h0, 16'h0, 24'h000060, 5);
      chk("R6", "inc absX carry", {mem[8'h61], mem[8'h60]}, 16'h8000);
      chk("R8", "absX 16 cost", cyc_count, exp_cost(8'hFE, 1'b1, 16'h0));
      mem[8'h20] = 8'h34; mem[8'h21] = 8'h12;
      issue(8'hE6, 1'b0, 1'b0, 16'h0, 16'h0, 16'h0, 16'h1234, 24'h000020, 5);
      chk("R6", "inc dp word", {mem[8'h21], mem[8'h20]}, 16'h1235);
      chk("R9", "dp 16 cost, nonzero low", cyc_count, exp_cost(8'hE6, 1'b1, 16'h1234));
      mem[8'h70] = 8'h00; mem[8'h71] = 8'h01;
      issue(8'hCE, 1'b0, 1'b0, 16'h0, 16'h0, 16'h0, 16'h0, 24'h000070, 5);
      chk("R6", "dec abs borrow", {mem[8'h71], mem[8'h70]}, 16'h00FF);
      chk("R8", "abs 16 cost", cyc_count, 4'd8);
   endtask

   task automatic t_illegal;
      int r0, w0;
      logic [15:0] a0;
      logic [3:0]  c0;
      a0 = acc_out; c0 = cyc_count;
      r0 = rd_cnt; w0 = wr_cnt;
      issue(8'hEA, 1'b0, 1'b0, 16'h7777, 16'h7777, 16'h7777, 16'h0, 24'h000040, 0);
      chk("R1", "illegal pulse", illegal, 1'b1);
      chk("R1", "no done", done, 1'b0);
      chk("R1", "acc unchanged", acc_out, a0);
      chk("R1", "cycles unchanged", cyc_count, c0);
      repeat (4) @(negedge clk);
      chk("R1", "no memory access", {16'(rd_cnt - r0), 16'(wr_cnt - w0)}, 32'h0);
      chk("R1", "illegal one cycle", illegal, 1'b0);
   endtask

   task automatic t_busy;
      mem[8'h44] = 8'h09;
      @(negedge clk);
      opcode = 8'hEE; m_flag = 1'b1; acc_in = 16'h0055; ea_in = 24'h000044; start = 1'b1;
      @(negedge clk);
      opcode = 8'h1A; acc_in = 16'h0100;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R10", "first op completes", done, 1'b1);
      chk("R10", "second start ignored", acc_out, 16'h0055);
      chk("R10", "memory updated", mem[8'h44], 8'h0A);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_reg16();
      t_reg8();
      t_mem8();
      t_mem16();
      t_illegal();
      t_busy();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL R11 watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule